// File: doc/BRIEF.md
# Soft-Reset and Enable Crossing Register Front End

This block is placed between a simple single-cycle register bus and a peripheral that runs on its own, slower clock. It holds a control register with a self-clearing soft-reset bit, an enable bit and a configuration field, a second configuration register, a debug register, and a read-only busy register. The configuration fields drive their outputs directly from the bus clock domain. The enable bit and the soft reset reach the peripheral clock domain through toggle handshakes, and each one has a busy flag that the bus can read.

A soft reset restores every register except the debug register to its reset value and turns the peripheral off. While the reset is in progress, bus writes are refused with an error and reads return reset values. The reset bit clears by itself once the peripheral domain has seen the reset and no enable handshake is left open. Register map: address 0 is CTRL (bit 0 soft reset, bit 1 enable, bits 8 and up the configuration field A), address 1 is MODE (configuration field B, reset value 0x5A), address 2 is DBG, and address 3 is BUSY (bit 0 reset busy, bit 1 enable busy).

Top module: `softrst_en_sync`

## Requirements
- R1: Writing 1 to CTRL bit 0 starts a soft reset. CTRL bit 0 and BUSY bit 0 then read 1, CTRL reads 0 in every other bit, and MODE reads 0x5A. A CTRL write with bit 0 at 0 does not start a reset.
- R2: When a CTRL write sets bit 0, the enable and configuration values in that same write are discarded.
- R3: Any write, to any address, while a soft reset is in progress asserts err_o in that access cycle and changes no register.
- R4: Reads while a soft reset is in progress return reset values (CTRL = 0x00000001, MODE = 0x5A) with err_o low.
- R5: The soft reset completes on its own. CTRL bit 0 and BUSY bit 0 return to 0, p_srst_o pulses exactly once in the peripheral domain, and p_en_o ends low, also when an enable handshake was in flight.
- R6: The DBG register keeps its value through a soft reset.
- R7: A written enable value reads back in CTRL bit 1 on the next access. BUSY bit 1 is 1 from then until p_en_o has taken the new value.
- R8: An enable written while an enable handshake is busy is accepted and read back. BUSY bit 1 stays 1, and p_en_o ends at the last written value.
- R9: BUSY is read-only. A write to it outside a soft reset changes nothing and gives no error.
- R10: Writes to configuration fields A and B appear on cfg_a_o and cfg_b_o one clock after the write, with no handshake.
- R11: Outside a soft reset, no read and no write asserts err_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Bus-domain asynchronous reset, active low |
| pclk_i | input | 1 | Peripheral clock |
| prst_ni | input | 1 | Peripheral-domain asynchronous reset, active low |
| sel_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| err_o | output | 1 | Access error, valid in the access cycle |
| cfg_a_o | output | 8 | Configuration field A |
| cfg_b_o | output | 8 | Configuration field B |
| dbg_o | output | 4 | Debug register value |
| p_en_o | output | 1 | Enable in the peripheral domain |
| p_srst_o | output | 1 | One-cycle soft-reset pulse in the peripheral domain |

## Verification
The hardest case to reach is a soft reset that arrives while an enable handshake is still in flight. The two toggles can land in the peripheral domain in either order, and completion has to wait for the enable channel to settle back to off. The bench sets the enable and then issues the soft-reset write on the very next bus cycle, so the enable request has not yet crossed. It then checks that the reset finishes, that both busy bits clear, and that p_en_o ends low. Writes refused during the reset are checked by reading the registers back after the reset completes.

// File: rtl/sres_pkg.sv
package sres_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_MODE = 2'd1,
    REG_DBG  = 2'd2,
    REG_BUSY = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_SRST_BIT = 0;
  localparam int unsigned CTRL_EN_BIT   = 1;
  localparam int unsigned CTRL_CFG_LSB  = 8;
  localparam int unsigned BUSY_SRST_BIT = 0;
  localparam int unsigned BUSY_EN_BIT   = 1;
  localparam int unsigned NUM_CHAN      = 2;
  localparam int unsigned CH_SRST       = 0;
  localparam int unsigned CH_EN         = 1;
endpackage

// File: rtl/sres_rst_sync.sv
module sres_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/sres_sync.sv
module sres_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/sres_bus_regs.sv
module sres_bus_regs
  import sres_pkg::*;
#(
  parameter int unsigned       DATA_W   = 32,
  parameter int unsigned       CFG_W    = 8,
  parameter int unsigned       DBG_W    = 4,
  parameter logic [CFG_W-1:0]  CFGB_RST = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic [CFG_W-1:0]  cfg_a_o,
  output logic [CFG_W-1:0]  cfg_b_o,
  output logic [DBG_W-1:0]  dbg_o,
  output logic              s_req_o,
  input  logic              s_ack_i,
  output logic              e_req_o,
  output logic              e_val_o,
  input  logic              e_ack_i,
  output logic              srst_o,
  output logic              en_rb_o,
  output logic              en_busy_o
);
  logic             srst_q, srst_d;
  logic             en_q, en_d;
  logic             s_req_q, s_req_d;
  logic             e_req_q, e_req_d;
  logic             e_val_q, e_val_d;
  logic [CFG_W-1:0] cfga_q, cfga_d;
  logic [CFG_W-1:0] cfgb_q, cfgb_d;
  logic [DBG_W-1:0] dbg_q, dbg_d;
  logic             cfga_en, cfgb_en, dbg_en;
  logic             wr_ok, s_hs_busy, e_hs_busy, e_pend;
  reg_addr_e        addr_e;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign addr_e    = reg_addr_e'(addr_i);
  assign wr_ok     = sel_i & we_i & ~srst_q;
  assign s_hs_busy = s_req_q ^ s_ack_i;
  assign e_hs_busy = e_req_q ^ e_ack_i;
  assign e_pend    = e_hs_busy | (en_q != e_val_q);

  // next-state logic
  always_comb begin
    srst_d  = srst_q;
    en_d    = en_q;
    s_req_d = s_req_q;
    e_req_d = e_req_q;
    e_val_d = e_val_q;
    cfga_d  = cfga_q;
    cfgb_d  = cfgb_q;
    dbg_d   = dbg_q;
    cfga_en = 1'b0;
    cfgb_en = 1'b0;
    dbg_en  = 1'b0;

    if (wr_ok) begin
      unique case (addr_e)
        REG_CTRL: begin
          cfga_en = 1'b1;
          if (wdata_i[CTRL_SRST_BIT]) begin
            srst_d  = 1'b1;
            s_req_d = ~s_req_q;
            en_d    = 1'b0;
            cfga_d  = '0;
            cfgb_d  = CFGB_RST;
            cfgb_en = 1'b1;
          end else begin
            en_d   = wdata_i[CTRL_EN_BIT];
            cfga_d = wdata_i[CTRL_CFG_LSB +: CFG_W];
          end
        end
        REG_MODE: begin
          cfgb_en = 1'b1;
          cfgb_d  = wdata_i[CFG_W-1:0];
        end
        REG_DBG: begin
          dbg_en = 1'b1;
          dbg_d  = wdata_i[DBG_W-1:0];
        end
        default: ;
      endcase
    end

    // launch a new enable handshake once the channel is idle
    if (!e_hs_busy && (en_q != e_val_q)) begin
      e_val_d = en_q;
      e_req_d = ~e_req_q;
    end

    // reset completes once both channels are quiet
    if (srst_q && !s_hs_busy && !e_pend) srst_d = 1'b0;
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q  <= 1'b0;
      en_q    <= 1'b0;
      s_req_q <= 1'b0;
      e_req_q <= 1'b0;
      e_val_q <= 1'b0;
    end else begin
      srst_q  <= srst_d;
      en_q    <= en_d;
      s_req_q <= s_req_d;
      e_req_q <= e_req_d;
      e_val_q <= e_val_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfga_q <= '0;
    else if (cfga_en) cfga_q <= cfga_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfgb_q <= CFGB_RST;
    else if (cfgb_en) cfgb_q <= cfgb_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dbg_q <= '0;
    else if (dbg_en) dbg_q <= dbg_d;
  end

  // read path
  always_comb begin
    rdata_o = '0;
    if (sel_i && !we_i) begin
      unique case (addr_e)
        REG_CTRL: begin
          rdata_o[CTRL_SRST_BIT]             = srst_q;
          rdata_o[CTRL_EN_BIT]               = en_q;
          rdata_o[CTRL_CFG_LSB +: CFG_W]     = cfga_q;
        end
        REG_MODE: rdata_o[CFG_W-1:0] = cfgb_q;
        REG_DBG:  rdata_o[DBG_W-1:0] = dbg_q;
        REG_BUSY: begin
          rdata_o[BUSY_SRST_BIT] = srst_q;
          rdata_o[BUSY_EN_BIT]   = e_pend;
        end
        default: ;
      endcase
    end
  end

  assign err_o     = sel_i & we_i & srst_q;
  assign cfg_a_o   = cfga_q;
  assign cfg_b_o   = cfgb_q;
  assign dbg_o     = dbg_q;
  assign s_req_o   = s_req_q;
  assign e_req_o   = e_req_q;
  assign e_val_o   = e_val_q;
  assign srst_o    = srst_q;
  assign en_rb_o   = en_q;
  assign en_busy_o = e_pend;
endmodule

// File: rtl/sres_pdom.sv
module sres_pdom (
  input  logic pclk_i,
  input  logic rst_ni,
  input  logic s_req_i,
  input  logic e_req_i,
  input  logic e_val_i,
  output logic s_ack_o,
  output logic e_ack_o,
  output logic p_en_o,
  output logic p_srst_o
);
  logic s_ack_q, s_ack_d;
  logic e_ack_q, e_ack_d;
  logic en_q, en_d;
  logic pulse_q, pulse_d;
  logic s_ev, e_ev;

  assign s_ev = s_req_i ^ s_ack_q;
  assign e_ev = e_req_i ^ e_ack_q;

  always_comb begin
    s_ack_d = s_req_i;
    e_ack_d = e_req_i;
    pulse_d = s_ev;
    en_d    = en_q;
    if (s_ev)      en_d = 1'b0;
    else if (e_ev) en_d = e_val_i;
  end

  always_ff @(posedge pclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_ack_q <= 1'b0;
      e_ack_q <= 1'b0;
      en_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      s_ack_q <= s_ack_d;
      e_ack_q <= e_ack_d;
      en_q    <= en_d;
      pulse_q <= pulse_d;
    end
  end

  assign s_ack_o  = s_ack_q;
  assign e_ack_o  = e_ack_q;
  assign p_en_o   = en_q;
  assign p_srst_o = pulse_q;
endmodule

// File: rtl/softrst_en_sync.sv
module softrst_en_sync
  import sres_pkg::*;
#(
  parameter int unsigned      DATA_W      = 32,
  parameter int unsigned      CFG_W       = 8,
  parameter int unsigned      DBG_W       = 4,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [CFG_W-1:0] CFGB_RST    = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pclk_i,
  input  logic              prst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic [CFG_W-1:0]  cfg_a_o,
  output logic [CFG_W-1:0]  cfg_b_o,
  output logic [DBG_W-1:0]  dbg_o,
  output logic              p_en_o,
  output logic              p_srst_o
);
  logic                bus_rst_n, per_rst_n;
  logic [NUM_CHAN-1:0] req_bus, req_per, ack_per, ack_bus;
  logic                e_val;
  logic                srst_busy, en_rb, en_busy;

  sres_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_bus (
    .clk_i(clk_i), .arst_ni(rst_ni), .rst_no(bus_rst_n));
  sres_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_per (
    .clk_i(pclk_i), .arst_ni(prst_ni), .rst_no(per_rst_n));

  sres_bus_regs #(
    .DATA_W(DATA_W), .CFG_W(CFG_W), .DBG_W(DBG_W), .CFGB_RST(CFGB_RST)
  ) u_bus (
    .clk_i(clk_i), .rst_ni(bus_rst_n),
    .sel_i(sel_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .err_o(err_o),
    .cfg_a_o(cfg_a_o), .cfg_b_o(cfg_b_o), .dbg_o(dbg_o),
    .s_req_o(req_bus[CH_SRST]), .s_ack_i(ack_bus[CH_SRST]),
    .e_req_o(req_bus[CH_EN]),   .e_val_o(e_val), .e_ack_i(ack_bus[CH_EN]),
    .srst_o(srst_busy), .en_rb_o(en_rb), .en_busy_o(en_busy));

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
    sres_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk_i(pclk_i), .rst_ni(per_rst_n), .d_i(req_bus[g]), .q_o(req_per[g]));
    sres_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk_i(clk_i), .rst_ni(bus_rst_n), .d_i(ack_per[g]), .q_o(ack_bus[g]));
  end

  sres_pdom u_pdom (
    .pclk_i(pclk_i), .rst_ni(per_rst_n),
    .s_req_i(req_per[CH_SRST]), .e_req_i(req_per[CH_EN]), .e_val_i(e_val),
    .s_ack_o(ack_per[CH_SRST]), .e_ack_o(ack_per[CH_EN]),
    .p_en_o(p_en_o), .p_srst_o(p_srst_o));
endmodule

// File: rtl/sres_checker.sv
module sres_checker
  import sres_pkg::*;
#(
  parameter int unsigned      DATA_W   = 32,
  parameter int unsigned      CFG_W    = 8,
  parameter int unsigned      DBG_W    = 4,
  parameter logic [CFG_W-1:0] CFGB_RST = 8'h5A
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pclk_i,
  input logic              prst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic [CFG_W-1:0]  cfg_a_o,
  input logic [CFG_W-1:0]  cfg_b_o,
  input logic [DBG_W-1:0]  dbg_o,
  input logic              p_srst_o,
  input logic              srst_busy,
  input logic              en_rb,
  input logic              en_busy
);
  logic wr_ctrl, wr_mode;
  assign wr_ctrl = sel_i & we_i & (addr_i == REG_CTRL) & ~srst_busy;
  assign wr_mode = sel_i & we_i & (addr_i == REG_MODE) & ~srst_busy;

  a_r3_err_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && srst_busy) |-> err_o);

  a_r11_err_only_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !srst_busy) |-> !err_o);

  a_r2_srst_discards: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && wdata_i[CTRL_SRST_BIT]) |=> (srst_busy && !en_rb && cfg_a_o == '0));

  a_r4_mode_reads_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && addr_i == REG_MODE && srst_busy) |-> rdata_o[CFG_W-1:0] == CFGB_RST);

  a_r5_clean_completion: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(srst_busy) |-> (!en_busy && !en_rb));

  a_r5_single_pulse: assert property (@(posedge pclk_i) disable iff (!prst_ni)
    p_srst_o |=> !p_srst_o);

  a_r6_dbg_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(srst_busy) |-> $stable(dbg_o));

  a_r7_busy_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !wdata_i[CTRL_SRST_BIT] && (wdata_i[CTRL_EN_BIT] != en_rb)) |=> en_busy);

  a_r10_mode_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mode |=> (cfg_b_o == $past(wdata_i[CFG_W-1:0])));
endmodule

bind softrst_en_sync sres_checker #(
  .DATA_W(DATA_W), .CFG_W(CFG_W), .DBG_W(DBG_W), .CFGB_RST(CFGB_RST)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pclk_i(pclk_i), .prst_ni(prst_ni),
  .sel_i(sel_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .err_o(err_o), .cfg_a_o(cfg_a_o), .cfg_b_o(cfg_b_o),
  .dbg_o(dbg_o), .p_srst_o(p_srst_o),
  .srst_busy(srst_busy), .en_rb(en_rb), .en_busy(en_busy));

// File: tb/softrst_en_sync_tb_top.sv
module softrst_en_sync_tb_top;
  logic        clk_i = 1'b0;
  logic        pclk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prst_ni = 1'b0;
  logic        sel_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o;
  logic [7:0]  cfg_a_o, cfg_b_o;
  logic [3:0]  dbg_o;
  logic        p_en_o, p_srst_o;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;
  always #6.5 pclk_i = ~pclk_i;

  always @(negedge pclk_i) if (p_srst_o) pulses++;

  softrst_en_sync dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pclk_i(pclk_i), .prst_ni(prst_ni),
    .sel_i(sel_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .err_o(err_o), .cfg_a_o(cfg_a_o), .cfg_b_o(cfg_b_o),
    .dbg_o(dbg_o), .p_en_o(p_en_o), .p_srst_o(p_srst_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d, output logic e);
    @(negedge clk_i);
    sel_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    #1 e = err_o;
    @(posedge clk_i);
    #1 sel_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d, output logic e);
    @(negedge clk_i);
    sel_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o; e = err_o;
    @(posedge clk_i);
    #1 sel_i = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] d;
    logic e;
    int n = 0;
    do begin
      bus_rd(2'd3, d, e);
      n++;
    end while (d[1:0] != 2'b00 && n < 400);
    check({req, " busy clears"}, {30'd0, d[1:0]}, 32'd0);
  endtask

  task automatic t_reset_state();
    logic [31:0] d; logic e;
    bus_rd(2'd0, d, e); check("R1 ctrl reset value", d, 32'h0);
    check("R11 read no error", {31'd0, e}, 32'd0);
    bus_rd(2'd1, d, e); check("R1 mode reset value", d, 32'h5A);
    bus_rd(2'd3, d, e); check("R1 busy idle", d, 32'h0);
    check("R5 p_en low at reset", {31'd0, p_en_o}, 32'd0);
  endtask

  task automatic t_config();
    logic [31:0] d; logic e;
    bus_wr(2'd0, 32'h0000_3C00, e);
    check("R11 write no error", {31'd0, e}, 32'd0);
    check("R10 cfg_a direct", {24'd0, cfg_a_o}, 32'h3C);
    bus_wr(2'd1, 32'h0000_0081, e);
    check("R10 cfg_b direct", {24'd0, cfg_b_o}, 32'h81);
    bus_rd(2'd3, d, e);
    check("R1 zero in bit0 starts no reset", d, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d; logic e;
    bus_wr(2'd0, 32'h0000_3C02, e);
    bus_rd(2'd0, d, e); check("R7 enable reads back", d, 32'h0000_3C02);
    bus_rd(2'd3, d, e); check("R7 enable busy set", d, 32'h2);
    wait_idle("R7");
    check("R7 p_en follows", {31'd0, p_en_o}, 32'd1);
  endtask

  task automatic t_enable_rewrite();
    logic [31:0] d; logic e;
    bus_wr(2'd0, 32'h0000_3C00, e);
    bus_wr(2'd0, 32'h0000_3C02, e);
    bus_wr(2'd0, 32'h0000_3C00, e);
    check("R8 write while busy accepted", {31'd0, e}, 32'd0);
    bus_rd(2'd0, d, e); check("R8 last enable reads back", d, 32'h0000_3C00);
    bus_rd(2'd3, d, e); check("R8 busy still set", d, 32'h2);
    wait_idle("R8");
    check("R8 p_en ends at last value", {31'd0, p_en_o}, 32'd0);
  endtask

  task automatic t_busy_ro();
    logic [31:0] d; logic e;
    bus_wr(2'd3, 32'hFFFF_FFFF, e);
    check("R9 busy write no error", {31'd0, e}, 32'd0);
    bus_rd(2'd3, d, e); check("R9 busy unchanged", d, 32'h0);
    bus_rd(2'd0, d, e); check("R9 ctrl untouched", d, 32'h0000_3C00);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d; logic e;
    int p0;
    bus_wr(2'd2, 32'h9, e);
    bus_wr(2'd1, 32'h12, e);
    bus_wr(2'd0, 32'h0000_5502, e);
    wait_idle("R7 pre-reset");
    p0 = pulses;
    bus_wr(2'd0, 32'h0000_FF03, e);
    check("R1 srst write no error", {31'd0, e}, 32'd0);
    bus_rd(2'd0, d, e); check("R2 R4 ctrl during reset", d, 32'h1);
    check("R4 read no error", {31'd0, e}, 32'd0);
    bus_rd(2'd1, d, e); check("R4 mode during reset", d, 32'h5A);
    bus_rd(2'd2, d, e); check("R6 dbg during reset", d, 32'h9);
    bus_rd(2'd3, d, e); check("R1 busy bit0 during reset", {31'd0, d[0]}, 32'd1);
    bus_wr(2'd1, 32'h33, e); check("R3 mode write errors", {31'd0, e}, 32'd1);
    bus_wr(2'd2, 32'h4, e);  check("R3 dbg write errors", {31'd0, e}, 32'd1);
    bus_wr(2'd0, 32'h2, e);  check("R3 ctrl write errors", {31'd0, e}, 32'd1);
    wait_idle("R5");
    bus_rd(2'd0, d, e); check("R5 ctrl after reset", d, 32'h0);
    bus_rd(2'd1, d, e); check("R3 refused mode write", d, 32'h5A);
    bus_rd(2'd2, d, e); check("R6 dbg kept", d, 32'h9);
    check("R5 p_en low", {31'd0, p_en_o}, 32'd0);
    check("R5 one pulse", pulses - p0, 32'd1);
  endtask

  task automatic t_reset_race();
    logic [31:0] d; logic e;
    int p0;
    p0 = pulses;
    bus_wr(2'd0, 32'h2, e);
    bus_wr(2'd0, 32'h1, e);
    wait_idle("R5 race");
    bus_rd(2'd0, d, e); check("R5 race ctrl", d, 32'h0);
    check("R5 race p_en low", {31'd0, p_en_o}, 32'd0);
    check("R5 race one pulse", pulses - p0, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #23 rst_ni = 1'b1; prst_ni = 1'b1;
    repeat (6) @(posedge pclk_i);
    t_reset_state();
    t_config();
    t_enable();
    t_enable_rewrite();
    t_busy_ro();
    t_soft_reset();
    t_reset_race();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule